// File: doc/BRIEF.md
# Gated Interrupt Enable and Latch Unit

This block gathers interrupt events for the device side of a full-speed USB controller. It takes six bus-level event pulses and fifteen per-endpoint event pulses and holds two 32-bit registers. The enable register is programmed by software. The status register latches events. Software reaches both registers through a small command port: a command byte selects the register and direction, and then two 16-bit data words move the value.

The enables gate *latching*. They do not mask latched status. An event pulse is recorded only if its enable bit was already 1 on the clock edge where the pulse is seen. An event that arrives while its bit is disabled is dropped for good, and turning the bit on later, even on that same edge, recovers nothing.

The block drives an active-low interrupt pin. The pin is low while any status bit is latched and the global interrupt enable input is high. Reading the status register clears it.

Top module: `irq_gate_unit`

## Requirements
- R1: After a synchronous reset, every enable bit and every status bit is 0, `int_n` is 1 and `rd_data` is 0.
- R2: Command 0xC2 followed by two `wr_valid` words loads the enable register. The first word carries bits 15:0 and the second carries bits 31:16. The register changes only on the edge of the second word. A transaction cut short by a new command leaves the register unchanged.
- R3: Command 0xC3 followed by two `rd_strobe` pulses returns enable bits 15:0 and then bits 31:16. Each word appears on `rd_data` in the cycle after its strobe.
- R4: Only these enable bits are implemented: bits 5:0 for the bus events, and bits 23:9 for endpoints 0 to 14 (endpoint n at bit n+9). The other bits (8:6 and 31:24) read back as 0 and ignore writes.
- R5: A status bit is set on an edge where its event pulse is high only if its enable bit was 1 before that edge. This holds even when the same edge commits a new enable value, and an event that was missed is never latched later.
- R6: The bus events occupy bits 0 to 5 in this order: start of frame, missed start of frame, end of transfer, suspend, resume, bus reset. A bus-reset event pulse does not change any enable bit.
- R7: Command 0xC0 followed by two `rd_strobe` pulses returns status bits 15:0 and then bits 31:16. The edge of the second strobe clears every latched bit, except that an enabled event pulse arriving on that same edge stays latched.
- R8: `int_n` is a register equal to the inverse of (`glb_ien` AND any status bit set), taken from the values of the previous cycle. It is therefore 1 whenever `glb_ien` is 0, and it rises one cycle after status becomes all zero.
- R9: Data words and read strobes that arrive outside a matching transaction are ignored, and so are unknown command codes. Neither register changes, and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe; starts a transaction |
| cmd_code | input | 8 | Command byte (0xC0, 0xC2, 0xC3) |
| wr_valid | input | 1 | Write data word strobe |
| wr_data | input | 16 | Write data word |
| rd_strobe | input | 1 | Read data word request |
| rd_data | output | 16 | Registered read data word |
| ev_bus | input | 6 | Bus event pulses, bit order as in R6 |
| ev_ep | input | 15 | Endpoint event pulses, endpoint n on bit n |
| glb_ien | input | 1 | Global interrupt enable for the pin |
| int_n | output | 1 | Active-low interrupt pin |

## Verification
The assertions assume that reset is held for at least two cycles. They also assume that every input is driven to a known level from time zero, so that values sampled with `$past` after reset are defined. Event inputs are treated as single-cycle pulses. A command strobe takes priority over any data word or read strobe in the same cycle.

The stimulus drives all inputs on the falling edge and releases each strobe after one cycle. It holds reset for five cycles. Random enable values, event bursts and `glb_ien` levels are drawn from a seeded `$urandom`. A few directed cases place an event on the same edge as an enable commit or as the clearing status read.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam logic [7:0] CMD_ST_RD = 8'hC0;
  localparam logic [7:0] CMD_EN_WR = 8'hC2;
  localparam logic [7:0] CMD_EN_RD = 8'hC3;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_EN_WR = 2'd1,
    M_EN_RD = 2'd2,
    M_ST_RD = 2'd3
  } xfer_mode_e;
endpackage

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
  import irq_gate_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int REG_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_strobe,
  input  logic [REG_W-1:0]  en_q,
  input  logic [REG_W-1:0]  st_q,
  output logic              commit,
  output logic [REG_W-1:0]  commit_val,
  output logic              st_clr,
  output logic [WORD_W-1:0] rd_data
);
  xfer_mode_e        mode;
  logic              word_idx;
  logic [WORD_W-1:0] lo_hold;
  logic [REG_W-1:0]  rd_src;
  logic              rd_mode;

  assign rd_src     = (mode == M_ST_RD) ? st_q : en_q;
  assign rd_mode    = (mode == M_EN_RD) || (mode == M_ST_RD);
  assign commit     = !cmd_valid && (mode == M_EN_WR) && wr_valid && word_idx;
  assign commit_val = {wr_data, lo_hold};
  assign st_clr     = !cmd_valid && (mode == M_ST_RD) && rd_strobe && word_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= M_IDLE;
      word_idx <= 1'b0;
      lo_hold  <= '0;
      rd_data  <= '0;
    end else if (cmd_valid) begin
      word_idx <= 1'b0;
      case (cmd_code)
        CMD_EN_WR: mode <= M_EN_WR;
        CMD_EN_RD: mode <= M_EN_RD;
        CMD_ST_RD: mode <= M_ST_RD;
        default:   mode <= M_IDLE;
      endcase
    end else if (mode == M_EN_WR && wr_valid) begin
      if (!word_idx) begin
        lo_hold  <= wr_data;
        word_idx <= 1'b1;
      end else begin
        word_idx <= 1'b0;
        mode     <= M_IDLE;
      end
    end else if (rd_mode && rd_strobe) begin
      rd_data  <= word_idx ? rd_src[REG_W-1:WORD_W] : rd_src[WORD_W-1:0];
      word_idx <= ~word_idx;
      if (word_idx) mode <= M_IDLE;
    end
  end

  AST_IDLE_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == M_IDLE && !cmd_valid && rd_strobe) |=> $stable(rd_data)); // R9
  AST_COMMIT_NEEDS_WRITE_MODE: assert property (@(posedge clk) disable iff (rst)
    commit |-> (mode == M_EN_WR && word_idx)); // R2
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int          REG_W = 32,
  parameter logic [31:0] MASK  = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [REG_W-1:0] commit_val,
  output logic [REG_W-1:0] en_q
);
  localparam logic [REG_W-1:0] IMPL = MASK[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (commit) en_q <= commit_val & IMPL;
  end

  AST_EN_HOLDS_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(en_q)); // R6
  AST_EN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (en_q & ~IMPL) == '0); // R4
endmodule

// File: rtl/irq_stat_latch.sv
module irq_stat_latch #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ev,
  input  logic [REG_W-1:0] en_q,
  input  logic             clr,
  input  logic             glb_ien,
  output logic [REG_W-1:0] st_q,
  output logic             int_n
);
  logic [REG_W-1:0] gated;

  assign gated = ev & en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      int_n <= 1'b1;
    end else begin
      st_q  <= (clr ? '0 : st_q) | gated;
      int_n <= ~(glb_ien & (|st_q));
    end
  end

  AST_NO_LATCH_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (st_q & ~$past(st_q) & ~$past(en_q)) == '0); // R5
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> ((st_q & ~$past(ev & en_q)) == '0)); // R7
  AST_PIN_OFF_WHEN_GLOBAL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$past(glb_ien) |-> int_n); // R8
  AST_PIN_HIGH_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    ($past(st_q) == '0) |-> int_n); // R8
endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit #(
  parameter int WORD_W  = 16,
  parameter int NUM_BUS = 6,
  parameter int NUM_EP  = 15,
  parameter int EP_BASE = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NUM_BUS-1:0] ev_bus,
  input  logic [NUM_EP-1:0]  ev_ep,
  input  logic              glb_ien,
  output logic              int_n
);
  localparam int REG_W = 2 * WORD_W;

  function automatic logic [31:0] impl_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < NUM_BUS; i++) m[i] = 1'b1;
    for (int j = 0; j < NUM_EP; j++)  m[EP_BASE + j] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] IMPL_MASK = impl_mask();

  logic [REG_W-1:0] ev_vec;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] st_q;
  logic [REG_W-1:0] commit_val;
  logic             commit;
  logic             st_clr;

  always_comb begin
    ev_vec = '0;
    for (int i = 0; i < NUM_BUS; i++) ev_vec[i] = ev_bus[i];
    for (int j = 0; j < NUM_EP; j++)  ev_vec[EP_BASE + j] = ev_ep[j];
  end

  irq_cmd_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .en_q(en_q), .st_q(st_q), .commit(commit), .commit_val(commit_val),
    .st_clr(st_clr), .rd_data(rd_data)
  );

  irq_en_reg #(.REG_W(REG_W), .MASK(IMPL_MASK)) u_en (
    .clk(clk), .rst(rst), .commit(commit), .commit_val(commit_val), .en_q(en_q)
  );

  irq_stat_latch #(.REG_W(REG_W)) u_st (
    .clk(clk), .rst(rst), .ev(ev_vec), .en_q(en_q), .clr(st_clr),
    .glb_ien(glb_ien), .st_q(st_q), .int_n(int_n)
  );
endmodule

// File: tb/tb_irq_gate_unit.sv
module tb_irq_gate_unit;
  localparam logic [31:0] MASK = 32'h00FF_FE3F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  ev_bus = '0;
  logic [14:0] ev_ep = '0;
  logic        glb_ien = 1'b0;
  logic        int_n;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] en_m = '0;
  logic [31:0] st_m = '0;

  always #4 clk = ~clk;

  irq_gate_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .ev_bus(ev_bus), .ev_ep(ev_ep),
    .glb_ien(glb_ien), .int_n(int_n)
  );

  function automatic logic exp_pin(logic g, logic [31:0] s);
    return ~(g & (|s));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ev(logic [31:0] e);
    ev_bus = e[5:0];
    ev_ep  = e[23:9];
  endtask

  task automatic cmd(logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr_word(logic [15:0] d, logic [31:0] e);
    wr_valid = 1'b1; wr_data = d; set_ev(e);
    @(negedge clk);
    wr_valid = 1'b0; set_ev('0);
  endtask

  task automatic rd_word(logic [31:0] e, output logic [15:0] d);
    rd_strobe = 1'b1; set_ev(e);
    @(negedge clk);
    rd_strobe = 1'b0; set_ev('0);
    d = rd_data;
  endtask

  task automatic write_en(logic [31:0] v);
    cmd(8'hC2);
    wr_word(v[15:0], '0);
    wr_word(v[31:16], '0);
    en_m = v & MASK;
  endtask

  task automatic read_reg(logic [7:0] c, output logic [31:0] v);
    logic [15:0] lo, hi;
    cmd(c);
    rd_word('0, lo);
    rd_word('0, hi);
    v = {hi, lo};
  endtask

  task automatic pulse(logic [31:0] e);
    set_ev(e);
    @(negedge clk);
    set_ev('0);
    st_m |= e & MASK & en_m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [15:0] w;
    void'($urandom(32'd1161));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 int_n", {31'd0, int_n}, 32'd1);
    check("R1 rd_data", {16'd0, rd_data}, 32'd0);
    read_reg(8'hC3, v); check("R1 enable", v, 32'd0);
    read_reg(8'hC0, v); check("R1 status", v, 32'd0);

    // R2 / R3 / R4 write then read back, reserved bits dropped
    write_en(32'hFFFF_FFFF);
    read_reg(8'hC3, v); check("R4 reserved read zero", v, MASK);
    write_en(32'h1234_5678);
    read_reg(8'hC3, v); check("R2 R3 word order", v, 32'h1234_5678 & MASK);

    // R2 abandoned write
    cmd(8'hC2); wr_word(16'hAAAA, '0); cmd(8'hC3);
    rd_word('0, w); rd_word('0, w);
    read_reg(8'hC3, v); check("R2 abandoned write", v, en_m);

    // R9 unknown command and stray words
    cmd(8'h55); wr_word(16'hFFFF, '0); wr_word(16'hFFFF, '0);
    read_reg(8'hC3, v); check("R9 unknown cmd", v, en_m);
    w = rd_data;
    rd_word('0, w); check("R9 idle read holds", {16'd0, rd_data}, {16'd0, v[31:16]});

    // R5 event while disabled is lost, even with enable set on the same edge
    write_en(32'h0);
    pulse(32'h0000_0001);
    cmd(8'hC2); wr_word(16'h0004, '0); wr_word(16'h0000, 32'h0000_0004);
    en_m = 32'h0000_0004;
    read_reg(8'hC0, v); check("R5 enable during event", v, 32'd0);
    pulse(32'h0000_0004);
    read_reg(8'hC0, v); check("R5 enabled event latched", v, 32'h0000_0004);
    st_m = '0;

    // R6 bus-reset event keeps enables
    write_en(32'h00FF_FE3F);
    pulse(32'h0000_0020);
    read_reg(8'hC3, v); check("R6 bus reset keeps enables", v, MASK);

    // R8 pin timing
    glb_ien = 1'b1;
    @(negedge clk);
    check("R8 pin low while latched", {31'd0, int_n}, 32'd0);
    read_reg(8'hC0, v); check("R7 status value", v, 32'h0000_0020);
    check("R8 pin lags clear", {31'd0, int_n}, 32'd0);
    @(negedge clk);
    check("R8 pin high after clear", {31'd0, int_n}, 32'd1);
    st_m = '0;

    // R7 event on the clearing edge stays latched
    pulse(32'h0001_0000);
    cmd(8'hC0); rd_word('0, w); rd_word(32'h0000_0200, w);
    check("R7 hi word before clear", {16'd0, w}, 32'h0000_0001);
    read_reg(8'hC0, v); check("R7 same-edge event kept", v, 32'h0000_0200);
    glb_ien = 1'b0;
    pulse(32'h0000_0001);
    @(negedge clk);
    check("R8 pin off with global low", {31'd0, int_n}, 32'd1);
    read_reg(8'hC0, v);
    st_m = '0;

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [31:0] rv;
      rv = $urandom;
      write_en(rv);
      read_reg(8'hC3, v); check("R2 R4 random enable", v, en_m);
      glb_ien = $urandom_range(0, 1);
      for (int k = 0; k < 4; k++) pulse($urandom & $urandom);
      @(negedge clk);
      check("R8 random pin", {31'd0, int_n}, {31'd0, exp_pin(glb_ien, st_m)});
      read_reg(8'hC0, v); check("R5 R7 random status", v, st_m);
      st_m = '0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule